// File: doc/BRIEF.md
# Load-Use Hazard Interlock Unit

This combinational unit sits between the decode and execute stages of a five-stage in-order pipeline. It looks at two instruction words: the one about to leave decode (held in the fetch/decode register) and the one currently in execute (held in the decode/execute register). When the execute-stage instruction is a load, the loaded value only becomes available at the end of the memory stage. If the decode-stage instruction needs that register as an ALU operand in its next cycle, forwarding cannot supply the value in time. In that case the unit inserts exactly one bubble.

To insert the bubble, it asserts a hold on the program counter and a hold on the fetch/decode register. It also raises a flush and presents a canonical no-op as the next execute-stage instruction word. When there is no hazard, the decode-stage word passes unchanged to the next execute-stage word. The register fields that are compared depend on the class of the consuming instruction. Instructions that sit two or three slots behind a load are never stalled. Forwarding serves the first case, and a register file that writes early and reads late in a cycle serves the second.

Instruction layout: opcode in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11. The opcode classes are:

| Opcode | Class |
|---|---|
| 0x00 | register-register ALU |
| 0x23 | load (destination in rt) |
| 0x2B | store |
| 0x04, 0x05 | branch |
| 0x08 to 0x0F | ALU-immediate |

Top module: `load_use_interlock`

## Requirements
- R1: When the execute-stage word has opcode 0x23 and its rt field (bits 20:16) is nonzero and equals the decode-stage rs field (bits 25:21), a stall is raised. This applies when the decode-stage opcode is 0x00, 0x23, 0x2B, 0x04, 0x05 or 0x08 to 0x0F.
- R2: When the decode-stage opcode is 0x00, a match between the load's rt and the decode-stage rt field (bits 20:16) also raises a stall.
- R3: When the decode-stage opcode is a load, store, branch or ALU-immediate, a match on its rt field alone raises no stall.
- R4: During a stall, flush_ex is 1 and ex_instr_next equals 32'h0000_0020, which is add R0,R0,R0.
- R5: During a stall, hold_pc and hold_fd are both 1. Without a stall, hold_pc, hold_fd and flush_ex are 0 and ex_instr_next equals fd_instr.
- R6: A non-load execute-stage instruction never raises a stall, even if it writes the register that the decode-stage instruction reads. The cases that rely on forwarding or on register-file timing therefore go through.
- R7: A load whose rt is R0 never raises a stall.
- R8: A decode-stage opcode outside the listed classes, such as 0x02, raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fd_instr | input | 32 | Instruction word in the fetch/decode register |
| ex_instr | input | 32 | Instruction word in the decode/execute register |
| hold_pc | output | 1 | Keep the program counter for one more cycle |
| hold_fd | output | 1 | Keep the fetch/decode register for one more cycle |
| flush_ex | output | 1 | Replace the next decode/execute word with the no-op |
| ex_instr_next | output | 32 | Word to load into the decode/execute register |

## Verification
The embedded assertions are immediate checks, and they are evaluated only when both instruction words are fully known. This means that an unknown word from an unfilled pipeline is not judged. The bench drives only complete, hand-built instruction words with every bit defined. It changes those words on the falling clock edge and samples the outputs one time unit later. Each pattern is chosen to hit one opcode class and one field match, so that each assertion sees both its triggering and non-triggering cases.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int unsigned IW     = 32,
  parameter int unsigned OPW    = 6,
  parameter int unsigned RW     = 5,
  parameter int unsigned OP_LSB = 26,
  parameter int unsigned RS_LSB = 21,
  parameter int unsigned RT_LSB = 16,
  parameter logic [OPW-1:0] OP_ALU_RR = 6'h00,
  parameter logic [OPW-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPW-1:0] OP_STORE  = 6'h2B,
  parameter logic [OPW-1:0] OP_BEQ    = 6'h04,
  parameter logic [OPW-1:0] OP_BNE    = 6'h05,
  parameter logic [OPW-1:0] OP_IMM_LO = 6'h08,
  parameter logic [OPW-1:0] OP_IMM_HI = 6'h0F,
  parameter logic [IW-1:0]  NOP_WORD  = 32'h0000_0020
) (
  input  logic [IW-1:0] fd_instr,
  input  logic [IW-1:0] ex_instr,
  output logic          hold_pc,
  output logic          hold_fd,
  output logic          flush_ex,
  output logic [IW-1:0] ex_instr_next
);

  logic [OPW-1:0] fd_op, ex_op;
  logic [RW-1:0]  fd_rs, fd_rt, ld_dst;
  logic           producer_load, fd_rr, fd_rs_reader;
  logic           rs_hit, rt_hit, bubble;

  assign fd_op  = fd_instr[OP_LSB +: OPW];
  assign ex_op  = ex_instr[OP_LSB +: OPW];
  assign fd_rs  = fd_instr[RS_LSB +: RW];
  assign fd_rt  = fd_instr[RT_LSB +: RW];
  assign ld_dst = ex_instr[RT_LSB +: RW];

  assign producer_load = (ex_op == OP_LOAD) && (ld_dst != '0);

  assign fd_rr = (fd_op == OP_ALU_RR);
  assign fd_rs_reader = fd_rr || (fd_op == OP_LOAD) || (fd_op == OP_STORE) ||
                        (fd_op == OP_BEQ) || (fd_op == OP_BNE) ||
                        ((fd_op >= OP_IMM_LO) && (fd_op <= OP_IMM_HI));

  assign rs_hit = fd_rs_reader && (fd_rs == ld_dst);
  assign rt_hit = fd_rr && (fd_rt == ld_dst);
  assign bubble = producer_load && (rs_hit || rt_hit);

  assign hold_pc       = bubble;
  assign hold_fd       = bubble;
  assign flush_ex      = bubble;
  assign ex_instr_next = bubble ? NOP_WORD : fd_instr;

  always_comb begin
    if (!$isunknown({fd_instr, ex_instr})) begin
      // R1 R6
      stall_needs_load_chk: assert (!hold_pc || ex_instr[OP_LSB +: OPW] == OP_LOAD);
      // R7
      zero_dest_quiet_chk: assert (ex_instr[RT_LSB +: RW] != '0 || !flush_ex);
      // R4
      bubble_word_chk: assert (!flush_ex || ex_instr_next == NOP_WORD);
      // R5
      pass_through_chk: assert (flush_ex || ex_instr_next == fd_instr);
      // R5
      hold_pair_chk: assert (hold_pc == hold_fd && hold_fd == flush_ex);
    end
  end

endmodule

// File: tb/load_use_interlock_test.sv
module load_use_interlock_test;
  logic        clk = 1'b0;
  logic [31:0] fd_instr, ex_instr, ex_instr_next;
  logic        hold_pc, hold_fd, flush_ex;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  localparam logic [31:0] NOP = 32'h0000_0020;

  always #4 clk = ~clk;

  load_use_interlock uut (
    .fd_instr(fd_instr), .ex_instr(ex_instr),
    .hold_pc(hold_pc), .hold_fd(hold_fd), .flush_ex(flush_ex),
    .ex_instr_next(ex_instr_next)
  );

  function automatic logic [31:0] rr(input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction

  function automatic logic [31:0] it(input logic [5:0] op, input int rs, input int rt);
    return {op, rs[4:0], rt[4:0], 16'h0010};
  endfunction

  task automatic apply_and_check(input string tag, input logic [31:0] ex_w,
                                 input logic [31:0] fd_w, input bit stall);
    logic [31:0] want;
    @(negedge clk);
    ex_instr = ex_w;
    fd_instr = fd_w;
    #1;
    want = stall ? NOP : fd_w;
    n_chk++;
    if (hold_pc !== stall || hold_fd !== stall || flush_ex !== stall || ex_instr_next !== want) begin
      n_bad++;
      $display("FAIL %s: hold_pc=%0b hold_fd=%0b flush=%0b next=%h expected stall=%0b next=%h",
               tag, hold_pc, hold_fd, flush_ex, ex_instr_next, stall, want);
    end
  endtask

  task automatic t_idle;
    apply_and_check("R5 idle nops", NOP, NOP, 0);
  endtask

  task automatic t_rs_classes;
    apply_and_check("R1 rr rs", it(6'h23, 2, 1), rr(4, 1, 5), 1);
    apply_and_check("R1 load rs", it(6'h23, 2, 3), it(6'h23, 3, 9), 1);
    apply_and_check("R1 store rs", it(6'h23, 2, 7), it(6'h2B, 7, 8), 1);
    apply_and_check("R1 beq rs", it(6'h23, 0, 31), it(6'h04, 31, 6), 1);
    apply_and_check("R1 bne rs", it(6'h23, 0, 12), it(6'h05, 12, 6), 1);
    apply_and_check("R1 imm lo rs", it(6'h23, 0, 5), it(6'h08, 5, 9), 1);
    apply_and_check("R1 imm hi rs", it(6'h23, 0, 5), it(6'h0F, 5, 9), 1);
  endtask

  task automatic t_rr_rt;
    apply_and_check("R2 rr rt", it(6'h23, 2, 1), rr(13, 6, 1), 1);
    apply_and_check("R2 rr both", it(6'h23, 2, 2), rr(14, 2, 2), 1);
  endtask

  task automatic t_rt_only;
    apply_and_check("R3 store rt", it(6'h23, 2, 15), it(6'h2B, 2, 15), 0);
    apply_and_check("R3 beq rt", it(6'h23, 2, 15), it(6'h04, 3, 15), 0);
    apply_and_check("R3 imm rt", it(6'h23, 2, 15), it(6'h0C, 3, 15), 0);
    apply_and_check("R3 load rt", it(6'h23, 2, 15), it(6'h23, 3, 15), 0);
  endtask

  task automatic t_bubble_word;
    apply_and_check("R4 bubble", it(6'h23, 9, 20), rr(21, 20, 22), 1);
    apply_and_check("R5 release", rr(0, 0, 0), rr(21, 20, 22), 0);
  endtask

  task automatic t_non_load;
    apply_and_check("R6 rr producer", rr(1, 2, 3), rr(5, 1, 1), 0);
    apply_and_check("R6 store producer", it(6'h2B, 2, 1), rr(5, 1, 1), 0);
    apply_and_check("R6 imm producer", it(6'h08, 2, 1), it(6'h23, 1, 4), 0);
    apply_and_check("R6 two behind", rr(5, 6, 7), rr(8, 1, 7), 0);
  endtask

  task automatic t_r0;
    apply_and_check("R7 load r0", it(6'h23, 2, 0), rr(4, 0, 0), 0);
    apply_and_check("R7 load r0 store", it(6'h23, 2, 0), it(6'h2B, 0, 0), 0);
  endtask

  task automatic t_other_op;
    apply_and_check("R8 jump", it(6'h23, 2, 1), it(6'h02, 1, 1), 0);
    apply_and_check("R8 op 0x3F", it(6'h23, 2, 1), it(6'h3F, 1, 1), 0);
  endtask

  initial begin
    fd_instr = NOP;
    ex_instr = NOP;
    t_idle();
    t_rs_classes();
    t_rr_rt();
    t_rt_only();
    t_bubble_word();
    t_non_load();
    t_r0();
    t_other_op();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule